// File: doc/BRIEF.md
# Microcoded Datapath ALU With Trailing Shifter

This unit is the arithmetic and logic stage of a microprogrammed datapath. Each microinstruction hands it two 32-bit operands, one usually from a scratch register and one from the operand bus. It also supplies a 6-bit function code and a 2-bit shift code. The unit returns, in the same cycle, the value that the register-write bus will carry. The function code is not an opcode. It is a set of control bits: two bits choose among AND, OR, NOT and add, two bits gate each operand to zero, one bit inverts the first operand, and one bit adds a carry-in. So one adder and a few gates cover pass-through, increment, decrement, negate and sum.

After the logic stage comes a shifter. It can move the result up by one byte, filling with zeros, or halve it as a signed value with an arithmetic shift right by one. Negative and zero flags are taken from the logic-stage result before the shifter. The sequencer uses them for conditional branching. The unit offers them both live and as registered copies captured at the clock edge, so the next microinstruction can test them.

The unit sits inside a lock-step datapath that gives a new microinstruction every cycle. It therefore has no valid/ready handshake and no back-pressure: every output is valid whenever its inputs are.

Top module: `mc_alu_shift`

## Requirements
- R1: `func` is decoded as func[5]=F0, func[4]=F1, func[3]=ENA, func[2]=ENB, func[1]=INVA, func[0]=INC. The first operand used inside the unit is `op_a` when ENA=1 and zero when ENA=0; INVA=1 then inverts it bitwise. The second operand is `op_b` when ENB=1 and zero when ENB=0.
- R2: With {F0,F1}=00 the logic result is the AND of the two operands, with 01 their OR, and with 10 the bitwise inverse of the second operand. INC has no effect in these three modes.
- R3: With {F0,F1}=11 the logic result is the sum of the two operands plus INC, taken modulo 2^32 so that a carry out of bit 31 is lost.
- R4: The codes 010100, 111100 and 110101 give B, A+B and B+1 respectively.
- R5: With shift = 2'b10 (shift[1] is the byte-left bit), `c_out` is the logic result moved left by 8 bits, with zeros in bits 7:0.
- R6: With shift = 2'b01 (shift[0] is the halve bit), `c_out` is the logic result shifted right by one, with bit 31 copied from the logic result's bit 31.
- R7: With shift = 2'b00 or 2'b11, `c_out` equals the unshifted logic result.
- R8: `n_now` is bit 31 of the logic result and `z_now` is 1 exactly when the logic result is all zeros. Both are taken before the shifter.
- R9: `n_q` and `z_q` take the values of `n_now` and `z_now` at each rising edge of `clk`, and hold them between edges. While `rst_n` is low they are 0.
- R10: `c_out`, `n_now` and `z_now` follow their inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag registers |
| rst_n | input | 1 | Asynchronous active-low reset of the flag registers |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| func | input | 6 | Function control bits F0 F1 ENA ENB INVA INC |
| shift | input | 2 | Shift control: bit 1 byte-left, bit 0 halve |
| c_out | output | 32 | Shifted result for the register-write bus |
| n_now | output | 1 | Live negative flag of the unshifted result |
| z_now | output | 1 | Live zero flag of the unshifted result |
| n_q | output | 1 | Registered negative flag |
| z_q | output | 1 | Registered zero flag |

## Verification
The bench sets up cases where the flags computed before the shift and after the shift differ. One case shifts a nonzero value to zero with the byte-left shift, and another moves a bit into the sign position. A design that took the flags after the shifter would report a false zero or a false negative there. It sets INC on the logic modes and checks that the result does not move, and it sends all-ones plus one through the adder to show that the carry out is dropped. It halves negative values and sets both shift bits together, which catches a logical shift in place of an arithmetic one and a priority mistake between the two shift bits. It also changes the inputs between clock edges, so a registered flag that follows its input without waiting for the edge is caught.

// File: rtl/mc_alu_pkg.sv
package mc_alu_pkg;

  // Logic-stage mode, encoded as {F0,F1}
  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTB = 2'b10,
    FN_SUM  = 2'b11
  } alu_fn_e;

  // Control word; field order matches func[5:0]
  typedef struct packed {
    alu_fn_e fn;
    logic    ena;
    logic    enb;
    logic    inva;
    logic    inc;
  } alu_ctl_t;

  // Shift control, bit 1 = byte-left, bit 0 = halve
  typedef enum logic [1:0] {
    SH_NONE = 2'b00,
    SH_HALF = 2'b01,
    SH_BYTE = 2'b10,
    SH_BOTH = 2'b11
  } shift_sel_e;

endpackage

// File: rtl/mc_alu_core.sv
module mc_alu_core
  import mc_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_ctl_t            ctl,
  input  logic [DATA_W-1:0]   a_in,
  input  logic [DATA_W-1:0]   b_in,
  output logic [DATA_W-1:0]   res
);

  logic [DATA_W-1:0] a_gated;
  logic [DATA_W-1:0] a_eff;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] carry_in;

  always_comb begin
    a_gated  = ctl.ena ? a_in : '0;
    a_eff    = ctl.inva ? ~a_gated : a_gated;
    b_eff    = ctl.enb ? b_in : '0;
    carry_in = {{(DATA_W-1){1'b0}}, ctl.inc};
  end

  // Carry out of the top bit is discarded by the result width
  always_comb begin
    case (ctl.fn)
      FN_AND:  res = a_eff & b_eff;
      FN_OR:   res = a_eff | b_eff;
      FN_NOTB: res = ~b_eff;
      FN_SUM:  res = a_eff + b_eff + carry_in;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/mc_alu_shifter.sv
module mc_alu_shifter
  import mc_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BYTE_SH = 8
) (
  input  shift_sel_e          sel,
  input  logic [DATA_W-1:0]   d_in,
  output logic [DATA_W-1:0]   d_out
);

  logic [DATA_W-1:0] up_val;
  logic [DATA_W-1:0] half_val;

  generate
    if (BYTE_SH > 0 && BYTE_SH < DATA_W) begin : g_up
      assign up_val = {d_in[DATA_W-BYTE_SH-1:0], {BYTE_SH{1'b0}}};
    end else begin : g_up_zero
      assign up_val = '0;
    end
  endgenerate

  assign half_val = {d_in[DATA_W-1], d_in[DATA_W-1:1]};

  always_comb begin
    case (sel)
      SH_BYTE: d_out = up_val;
      SH_HALF: d_out = half_val;
      default: d_out = d_in;
    endcase
  end

endmodule

// File: rtl/mc_flag_reg.sv
module mc_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic n_d,
  input  logic z_d,
  output logic n_q,
  output logic z_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= 1'b0;
      z_q <= 1'b0;
    end else begin
      n_q <= n_d;
      z_q <= z_d;
    end
  end

  // R9
  flag_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (n_q == $past(n_d)) && (z_q == $past(z_d)));

endmodule

// File: rtl/mc_alu_shift.sv
module mc_alu_shift
  import mc_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BYTE_SH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [5:0]        func,
  input  logic [1:0]        shift,
  output logic [DATA_W-1:0] c_out,
  output logic              n_now,
  output logic              z_now,
  output logic              n_q,
  output logic              z_q
);

  localparam int MSB = DATA_W - 1;

  alu_ctl_t          ctl;
  shift_sel_e        sh_sel;
  logic [DATA_W-1:0] alu_res;

  assign ctl    = alu_ctl_t'(func);
  assign sh_sel = shift_sel_e'(shift);

  mc_alu_core #(.DATA_W(DATA_W)) u_core (
    .ctl  (ctl),
    .a_in (op_a),
    .b_in (op_b),
    .res  (alu_res)
  );

  mc_alu_shifter #(.DATA_W(DATA_W), .BYTE_SH(BYTE_SH)) u_shift (
    .sel   (sh_sel),
    .d_in  (alu_res),
    .d_out (c_out)
  );

  // Flags come from the logic stage, ahead of the shifter
  assign n_now = alu_res[MSB];
  assign z_now = (alu_res == '0);

  mc_flag_reg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .n_d   (n_now),
    .z_d   (z_now),
    .n_q   (n_q),
    .z_q   (z_q)
  );

  // R5
  byte_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift == 2'b10) |-> (c_out[BYTE_SH-1:0] == '0));

  // R6
  half_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift == 2'b01) |-> (c_out[MSB] == n_now));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (z_now && (shift != 2'b10)) |-> (c_out == '0));

  // R4
  pass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (func == 6'b010100 && (shift == 2'b00)) |-> (c_out == op_b));

endmodule

// File: tb/sim_mc_alu_shift.sv
module sim_mc_alu_shift;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [5:0]  func = '0;
  logic [1:0]  shift = '0;
  logic [31:0] c_out;
  logic        n_now, z_now, n_q, z_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mc_alu_shift u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .func(func), .shift(shift), .c_out(c_out),
    .n_now(n_now), .z_now(z_now), .n_q(n_q), .z_q(z_q)
  );

  function automatic logic [31:0] ref_alu(logic [31:0] a, logic [31:0] b, logic [5:0] f);
    logic [31:0] x, y;
    x = f[3] ? a : 32'h0;
    if (f[1]) x = ~x;
    y = f[2] ? b : 32'h0;
    case (f[5:4])
      2'b00:   return x & y;
      2'b01:   return x | y;
      2'b10:   return ~y;
      default: return x + y + {31'h0, f[0]};
    endcase
  endfunction

  function automatic logic [31:0] ref_sh(logic [31:0] v, logic [1:0] s);
    if (s == 2'b10) return v << 8;
    if (s == 2'b01) return {v[31], v[31:1]};
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive after a falling edge, sample 1 ns later (no clock edge between)
  task automatic apply(logic [31:0] a, logic [31:0] b, logic [5:0] f, logic [1:0] s);
    @(negedge clk);
    op_a = a; op_b = b; func = f; shift = s;
    #1;
  endtask

  task automatic run_vec(string req, logic [31:0] a, logic [31:0] b, logic [5:0] f, logic [1:0] s);
    logic [31:0] r;
    apply(a, b, f, s);
    r = ref_alu(a, b, f);
    chk(req, c_out, ref_sh(r, s));
    chk({req, " N"}, {31'h0, n_now}, {31'h0, r[31]});
    chk({req, " Z"}, {31'h0, z_now}, {31'h0, (r == 32'h0)});
  endtask

  task automatic t_reset;
    apply(32'h0, 32'h0, 6'b010100, 2'b00);
    chk("R9 reset n_q", {31'h0, n_q}, 32'h0);
    chk("R9 reset z_q", {31'h0, z_q}, 32'h0);
  endtask

  task automatic t_canonical;
    apply(32'h1234_5678, 32'h0000_00FF, 6'b010100, 2'b00);
    chk("R4 pass B", c_out, 32'h0000_00FF);
    apply(32'h1234_5678, 32'h0000_00FF, 6'b111100, 2'b00);
    chk("R4 A+B", c_out, 32'h1234_5777);
    apply(32'h1234_5678, 32'h0000_00FF, 6'b110101, 2'b00);
    chk("R4 B+1", c_out, 32'h0000_0100);
  endtask

  task automatic t_logic;
    apply(32'hF0F0_1234, 32'h0FF0_FF00, 6'b001100, 2'b00);
    chk("R2 AND", c_out, 32'h00F0_1200);
    apply(32'hF0F0_1234, 32'h0FF0_FF00, 6'b011100, 2'b00);
    chk("R2 OR", c_out, 32'hFFF0_FF34);
    apply(32'hF0F0_1234, 32'h0FF0_FF00, 6'b101100, 2'b00);
    chk("R2 NOT B", c_out, 32'hF00F_00FF);
    apply(32'hF0F0_1234, 32'h0FF0_FF00, 6'b001101, 2'b00);
    chk("R2 INC ignored AND", c_out, 32'h00F0_1200);
    apply(32'hF0F0_1234, 32'h0FF0_FF00, 6'b101101, 2'b00);
    chk("R2 INC ignored NOT B", c_out, 32'hF00F_00FF);
    run_vec("R2 OR inva", 32'h0000_FFFF, 32'h0000_0001, 6'b011110, 2'b00);
  endtask

  task automatic t_gating;
    apply(32'h1111_1111, 32'h2222_2222, 6'b110100, 2'b00);
    chk("R1 ENA off", c_out, 32'h2222_2222);
    apply(32'h1111_1111, 32'h2222_2222, 6'b111000, 2'b00);
    chk("R1 ENB off", c_out, 32'h1111_1111);
    apply(32'h1111_1111, 32'h2222_2222, 6'b110010, 2'b00);
    chk("R1 INVA of gated zero", c_out, 32'hFFFF_FFFF);
    apply(32'h0000_0005, 32'h0, 6'b111011, 2'b00);
    chk("R1 negate A", c_out, 32'hFFFF_FFFB);
  endtask

  task automatic t_sum;
    apply(32'hFFFF_FFFF, 32'h0000_0001, 6'b111100, 2'b00);
    chk("R3 wrap", c_out, 32'h0);
    chk("R3 wrap Z", {31'h0, z_now}, 32'h1);
    apply(32'hFFFF_FFFF, 32'h0, 6'b111101, 2'b00);
    chk("R3 carry-in wrap", c_out, 32'h0);
    apply(32'h7FFF_FFFF, 32'h0000_0001, 6'b111100, 2'b00);
    chk("R3 into sign", c_out, 32'h8000_0000);
    chk("R8 N on sum", {31'h0, n_now}, 32'h1);
    run_vec("R3 mix", 32'hDEAD_BEEF, 32'h1357_9BDF, 6'b111101, 2'b00);
  endtask

  task automatic t_shift;
    apply(32'h0, 32'h8000_0001, 6'b010100, 2'b01);
    chk("R6 halve negative", c_out, 32'hC000_0000);
    apply(32'h0, 32'h4000_0002, 6'b010100, 2'b01);
    chk("R6 halve positive", c_out, 32'h2000_0001);
    apply(32'h0, 32'h8000_0001, 6'b010100, 2'b10);
    chk("R5 byte left", c_out, 32'h0000_0100);
    apply(32'h0, 32'h8000_0001, 6'b010100, 2'b11);
    chk("R7 both bits", c_out, 32'h8000_0001);
    apply(32'h0, 32'h8000_0001, 6'b010100, 2'b00);
    chk("R7 none", c_out, 32'h8000_0001);
    run_vec("R5 sum shifted", 32'h00AB_CDEF, 32'h0000_0011, 6'b111100, 2'b10);
  endtask

  task automatic t_flags;
    apply(32'h0, 32'h0100_0000, 6'b010100, 2'b10);
    chk("R8 shifted to zero c_out", c_out, 32'h0);
    chk("R8 Z before shift", {31'h0, z_now}, 32'h0);
    apply(32'h0, 32'h0080_0000, 6'b010100, 2'b10);
    chk("R8 shifted into sign c_out", c_out, 32'h8000_0000);
    chk("R8 N before shift", {31'h0, n_now}, 32'h0);
    apply(32'h0, 32'h0000_0001, 6'b010100, 2'b01);
    chk("R8 halved to zero c_out", c_out, 32'h0);
    chk("R8 Z not from halve", {31'h0, z_now}, 32'h0);
    apply(32'h0, 32'h0000_0000, 6'b010100, 2'b00);
    chk("R10 live Z without edge", {31'h0, z_now}, 32'h1);
  endtask

  task automatic t_flag_reg;
    apply(32'h0, 32'h8000_0000, 6'b010100, 2'b00);   // N=1 Z=0
    @(negedge clk);
    chk("R9 n_q captured", {31'h0, n_q}, 32'h1);
    chk("R9 z_q captured", {31'h0, z_q}, 32'h0);
    op_b = 32'h0; #1;                                  // N=0 Z=1, no edge yet
    chk("R9 n_q holds between edges", {31'h0, n_q}, 32'h1);
    chk("R9 z_q holds between edges", {31'h0, z_q}, 32'h0);
    @(negedge clk);
    chk("R9 n_q next edge", {31'h0, n_q}, 32'h0);
    chk("R9 z_q next edge", {31'h0, z_q}, 32'h1);
    rst_n = 1'b0; #1;
    chk("R9 async clear z_q", {31'h0, z_q}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_canonical();
    t_logic();
    t_gating();
    t_sum();
    t_shift();
    t_flags();
    t_flag_reg();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule